// File: doc/BRIEF.md
# Line Sync Regenerator

This block takes the horizontal and vertical sync recovered from a display link, where the horizontal sync pulse may land one pixel clock early or late from line to line, and rebuilds both syncs so that their leading edges sit at a fixed distance from the end of active video. The end of active video is the falling edge of the data-enable signal. Data enable stays fixed relative to the pixel data, so the block uses it as the timing reference.

On every line the block counts pixel clocks from the data-enable falling edge to the sync leading edge, and it measures the pulse width. It also samples the sync polarity at the data-enable falling edge. A locked offset and a locked width change only when two lines in a row disagree with them by more than one clock. Each locked value takes effect at the next line start. Until the first pulse has been measured, the sync passes straight through, delayed by the same latency as the rebuilt path. An input that is already stable therefore leaves with identical timing. During vertical blanking data enable does not fall, so the line position keeps running on the measured line period.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted and until the first pulse arrives afterwards, `hs_out` and `vs_out` are both 0.
- R2: Until the first pulse after a data-enable falling edge has been measured, `hs_out` equals `hs_in` delayed by exactly `LAT` clocks. The leading edge is at input position + `LAT`, and the width is unchanged.
- R3: The first complete pulse measured after a data-enable fall sets the locked offset and width. From the next line start, the output pulse begins at position locked offset + `LAT` and lasts the locked width, whatever the input does. Position 0 is the first clock with `de_in` low.
- R4: An input leading edge within one clock of the locked offset leaves the output unchanged. A stable input yields the same output as the straight-through path.
- R5: The locked offset moves only after two consecutive lines each measure an offset more than one clock away from it. The new value applies from the following line start. A single outlying line is ignored.
- R6: The locked width follows the same two-line rule, with a difference of more than one clock.
- R7: The active sync level is the inverse of `hs_in` at the data-enable falling edge. `hs_out` idles at the inverse of the active level and pulses to the active level.
- R8: `vs_out` takes the `vs_in` level seen at the input sync leading edge. It changes only in the clock where `hs_out` shows its leading edge, not when `vs_in` changes.
- R9: On lines where `de_in` stays low, line starts repeat at the last measured period between data-enable falls. Regeneration continues at the locked offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de_in | input | 1 | Data enable, high in active video |
| hs_in | input | 1 | Received horizontal sync, may wander by one clock |
| vs_in | input | 1 | Received vertical sync |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Regenerated vertical sync |

## Verification
The stimulus covers four families of lines:
- A first pulse with a distinct width shows the straight-through delay before lock, and then shows that the locked width overrides a different later input.
- Offsets of 4, 5 and 6 around a lock at 5 show the tolerance window. A lone line at 8 shows that an outlier is rejected, and three lines at 8 show when a move takes effect.
- Active-low pulses show polarity sensing. A `vs_in` change at the line start shows that the vertical sync waits for the regenerated leading edge.
- Lines with data enable held low show that the line position survives blanking.

// File: rtl/hsync_regen.sv
module hsync_regen #(
  parameter int CW  = 12,
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  input  logic hs_in,
  input  logic vs_in,
  output logic hs_out,
  output logic vs_out
);
  localparam logic [CW-1:0] C1   = CW'(1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW:0]   ONE  = (CW+1)'(1);
  localparam logic [CW:0]   LATW = (CW+1)'(LAT);

  logic de_q, started, pol, seen, in_pulse, have, po, pw, locked, vs_cap, vs_hold;
  logic [CW-1:0] cnt, pcnt, len, m_off, wcnt, off_nx, wid_nx, off, wid;
  logic [LAT-1:0] dly;

  function automatic logic far(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return ({1'b0, a} > {1'b0, b} + ONE) || ({1'b0, b} > {1'b0, a} + ONE);
  endfunction

  wire de_fall    = de_q & ~de_in;
  wire line_start = de_fall | (cnt == '0);
  wire hs_act     = (hs_in == pol);
  wire lead       = started & ~seen & ~line_start & ~de_in & hs_act;
  wire trail      = in_pulse & ~hs_act;

  wire [CW:0] win_lo = {1'b0, off} + LATW;
  wire [CW:0] win_hi = win_lo + {1'b0, wid};
  wire [CW:0] pos    = {1'b0, cnt};
  wire in_win        = ~line_start & (pos >= win_lo) & (pos < win_hi);

  wire lead_next = locked ? (~line_start & (pos + ONE == win_lo))
                          : ((dly[LAT-2] == pol) & (dly[LAT-1] != pol));

  assign hs_out = locked ? (in_win ? pol : ~pol) : dly[LAT-1];
  assign vs_out = vs_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0; started <= 1'b0; pol <= 1'b1;
      cnt <= C1; pcnt <= '0; len <= CMAX;
      seen <= 1'b0; in_pulse <= 1'b0; m_off <= '0; wcnt <= '0;
      have <= 1'b0; po <= 1'b0; pw <= 1'b0; off_nx <= '0; wid_nx <= '0;
      locked <= 1'b0; off <= '0; wid <= '0;
      dly <= '0; vs_cap <= 1'b0; vs_hold <= 1'b0;
    end else begin
      de_q <= de_in;
      dly  <= {dly[LAT-2:0], hs_in};

      if (de_fall) begin
        cnt <= C1;
        pcnt <= C1;
        started <= 1'b1;
        pol <= ~hs_in;
        if (started) len <= pcnt;
      end else begin
        cnt <= (cnt == len - C1) ? '0 : cnt + C1;
        if (pcnt != CMAX) pcnt <= pcnt + C1;
      end

      if (line_start) seen <= 1'b0;
      else if (lead)  seen <= 1'b1;

      if (lead) begin
        in_pulse <= 1'b1;
        wcnt <= C1;
        m_off <= cnt;
        vs_cap <= vs_in;
      end else if (trail) begin
        in_pulse <= 1'b0;
      end else if (in_pulse && wcnt != CMAX) begin
        wcnt <= wcnt + C1;
      end

      if (trail) begin
        if (!have) begin
          have <= 1'b1;
          off_nx <= m_off;
          wid_nx <= wcnt;
        end else begin
          if (far(m_off, off_nx)) begin
            if (po) off_nx <= m_off;
            po <= ~po;
          end else po <= 1'b0;
          if (far(wcnt, wid_nx)) begin
            if (pw) wid_nx <= wcnt;
            pw <= ~pw;
          end else pw <= 1'b0;
        end
      end

      if (line_start) begin
        locked <= have;
        off <= off_nx;
        wid <= wid_nx;
      end

      if (lead_next) vs_hold <= vs_cap;
    end
  end
endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
  parameter int CW  = 12,
  parameter int LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_in,
  input logic          hs_out,
  input logic          vs_out,
  input logic          locked,
  input logic          pol,
  input logic [CW-1:0] off,
  input logic [CW-1:0] wid,
  input logic          line_start
);
  localparam logic [CW:0] ONE = (CW+1)'(1);
  logic [LAT-1:0] mir;
  logic [CW:0]    run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mir <= '0;
      run <= '0;
    end else begin
      mir <= {mir[LAT-2:0], hs_in};
      run <= (locked && hs_out == pol) ? run + ONE : '0;
    end
  end

  // R2
  pass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> hs_out == mir[LAT-1]);

  // R8
  vs_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vs_out) |-> !$stable(hs_out));

  // R5
  off_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off) |-> $past(line_start));

  // R6
  wid_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wid) |-> $past(line_start));

  // R3
  width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> run <= {1'b0, wid});
endmodule

bind hsync_regen hsync_regen_chk #(.CW(CW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .hs_out(hs_out), .vs_out(vs_out),
  .locked(locked), .pol(pol), .off(off), .wid(wid), .line_start(line_start)
);

// File: tb/hsync_regen_bench.sv
module hsync_regen_bench;
  localparam int LAT = 4;
  localparam int BL  = 20;
  localparam int NL  = 40;

  logic clk = 1'b0, rst_n = 1'b0, de = 1'b1, hs = 1'b0, vs = 1'b0;
  logic hs_out, vs_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsync_regen #(.CW(12), .LAT(LAT)) u_hsync_regen (
    .clk(clk), .rst_n(rst_n), .de_in(de), .hs_in(hs), .vs_in(vs),
    .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_line(input int off, input int w, input bit neg, input bit vsv,
                          input bit de_on, output int lead, output int wout,
                          output int vs_pre, output int vs_at, output int idle);
    bit act, inrun;
    int prev_vs;
    act = ~neg; inrun = 1'b0; prev_vs = 0;
    lead = -1; wout = 0; vs_pre = -1; vs_at = -1; idle = -1;
    for (int p = 0; p < NL; p++) begin
      @(posedge clk); #1;
      de = de_on && (p >= BL);
      hs = (p >= off && p < off + w) ? act : ~act;
      vs = vsv;
      @(negedge clk);
      if (p == 2) idle = int'(hs_out);
      if (p >= 1) begin
        if (lead < 0 && hs_out == act) begin
          lead = p; vs_pre = prev_vs; vs_at = int'(vs_out); inrun = 1'b1;
        end
        if (inrun) begin
          if (hs_out == act) wout++;
          else inrun = 1'b0;
        end
      end
      prev_vs = int'(vs_out);
    end
  endtask

  task automatic line_expect(input string tag, input int off, input int w, input bit neg,
                             input bit de_on, input int exp_lead, input int exp_w);
    int ld, wd, vp, va, idl;
    run_line(off, w, neg, 1'b0, de_on, ld, wd, vp, va, idl);
    check({tag, " lead"}, ld, exp_lead);
    check({tag, " width"}, wd, exp_w);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; de = 1'b1; hs = 1'b0; vs = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 hs_out in reset", int'(hs_out), 0);
    check("R1 vs_out in reset", int'(vs_out), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 hs_out after reset", int'(hs_out), 0);
    check("R1 vs_out after reset", int'(vs_out), 0);
  endtask

  task automatic t_passthru;
    line_expect("R2 first line delayed", 5, 3, 1'b0, 1'b1, 5 + LAT, 3);
  endtask

  task automatic t_lock_first;
    line_expect("R3 locked values used", 4, 6, 1'b0, 1'b1, 5 + LAT, 3);
  endtask

  task automatic t_width_filter;
    line_expect("R6 width second far line", 4, 6, 1'b0, 1'b1, 5 + LAT, 3);
    line_expect("R6 width moved", 4, 6, 1'b0, 1'b1, 5 + LAT, 6);
  endtask

  task automatic t_jitter;
    line_expect("R4 jitter 4", 4, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R4 jitter 6", 6, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R4 stable 5 transparent", 5, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R4 jitter 4b", 4, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R4 jitter 6b", 6, 6, 1'b0, 1'b1, 5 + LAT, 6);
  endtask

  task automatic t_outlier;
    line_expect("R5 outlier 8", 8, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R5 back to 5", 5, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R5 outlier 8 again", 8, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R5 back to 5 again", 5, 6, 1'b0, 1'b1, 5 + LAT, 6);
  endtask

  task automatic t_offset_move;
    line_expect("R5 move first line", 8, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R5 move second line", 8, 6, 1'b0, 1'b1, 5 + LAT, 6);
    line_expect("R5 move applied", 8, 6, 1'b0, 1'b1, 8 + LAT, 6);
    line_expect("R5 return first", 5, 6, 1'b0, 1'b1, 8 + LAT, 6);
    line_expect("R5 return second", 5, 6, 1'b0, 1'b1, 8 + LAT, 6);
    line_expect("R5 return applied", 5, 6, 1'b0, 1'b1, 5 + LAT, 6);
  endtask

  task automatic t_polarity;
    int ld, wd, vp, va, idl;
    for (int k = 0; k < 2; k++) begin
      run_line(5, 6, 1'b1, 1'b0, 1'b1, ld, wd, vp, va, idl);
      check("R7 low-active lead", ld, 5 + LAT);
      check("R7 low-active width", wd, 6);
      check("R7 idle high", idl, 1);
    end
    run_line(5, 6, 1'b0, 1'b0, 1'b1, ld, wd, vp, va, idl);
    check("R7 high-active lead", ld, 5 + LAT);
    check("R7 idle low", idl, 0);
  endtask

  task automatic t_vsync;
    int ld, wd, vp, va, idl;
    run_line(5, 6, 1'b0, 1'b1, 1'b1, ld, wd, vp, va, idl);
    check("R8 vs held before edge", vp, 0);
    check("R8 vs at edge", va, 1);
    check("R8 lead", ld, 5 + LAT);
    run_line(5, 6, 1'b0, 1'b0, 1'b1, ld, wd, vp, va, idl);
    check("R8 vs held high before edge", vp, 1);
    check("R8 vs falls at edge", va, 0);
  endtask

  task automatic t_blanking;
    int ld, wd, vp, va, idl;
    for (int k = 0; k < 3; k++) begin
      run_line(5, 6, 1'b0, 1'b1, 1'b0, ld, wd, vp, va, idl);
      check("R9 blank line lead", ld, 5 + LAT);
      check("R9 blank line width", wd, 6);
      check("R9 blank line vs", va, 1);
    end
    line_expect("R9 first line after blanking", 5, 6, 1'b0, 1'b1, 5 + LAT, 6);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_lock_first();
    t_width_filter();
    t_jitter();
    t_outlier();
    t_offset_move();
    t_polarity();
    t_vsync();
    t_blanking();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule